// File: doc/BRIEF.md
# Programmable Pulse Generator Timer

This block is a free-running 16-bit up-counter with two compare values that drives one square-wave output. The first compare value sets the length of one output cycle. The second sets how long the output stays at its starting level inside that cycle. An output flip-flop inverts whenever the counter equals either compare value. The counter returns to zero after it reaches the cycle-length value, so the waveform repeats every (cycle value + 1) clocks.

Both compare values are captured into shadow copies while the timer is idle, and again at each counter clear while it runs. A compare value written in the middle of a cycle therefore takes effect only from the next cycle. The starting level of the flip-flop is programmed with separate set and clear controls while the timer is stopped. An enable bit decides whether the flip-flop reaches the pin. Legal settings satisfy 0 < width value < cycle value <= 0xFFFF.

Top module: `ppg_timer`

## Requirements
- R1: With `run` low the counter stays at zero. After `run` rises, the first output toggle follows the first edge at which the count equals the width value, W clocks after the first running edge.
- R2: The waveform repeats every P+1 clocks, where P is the active cycle value, because the counter goes from P back to 0.
- R3: With starting level L, the output holds L for W+1 clocks of each cycle, where W is the active width value. Sampled after running edge j, the output equals L when (j mod (P+1)) is P or less than W.
- R4: In each cycle the output holds the inverse of L for P-W clocks.
- R5: With `out_en` low the pin is 0 whatever the flip-flop holds. The flip-flop keeps toggling, so raising `out_en` again shows the waveform still in phase.
- R6: A high `lvl_set` forces the flip-flop to 1 at the next edge. A high `lvl_clr` forces it to 0. When both are high, the flip-flop goes to 0.
- R7: While `run` is low and neither level control is high, the flip-flop keeps its level.
- R8: Compare values that change while the timer runs are not used until the edge at which the counter clears. The cycle that follows the clear then uses the new values.
- R9: The flip-flop is 0 after the synchronous reset `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Counter run enable |
| period_cmp | input | 16 | Cycle compare value P |
| width_cmp | input | 16 | Width compare value W |
| out_en | input | 1 | Gates the flip-flop onto the pin |
| lvl_set | input | 1 | Forces the flip-flop to 1 |
| lvl_clr | input | 1 | Forces the flip-flop to 0 (has priority) |
| pulse_o | output | 1 | Pulse output |

## Verification
Every result appears one edge after the stimulus that causes it. A level control, or a compare match on count c, changes `pulse_o` right after the next rising edge. `out_en` acts on the pin at once, in the same cycle. The bench drives inputs on falling edges and samples the pin on the next falling edge. After the j-th running edge it compares the pin with an independent model that tracks the count and the active compare pair. A compare change reaches the model only at the edge where its own count equals its active cycle value.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
    localparam int unsigned PPG_W = 16;

    typedef logic [PPG_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t period;
        cnt_t width;
    } cmp_pair_t;

    typedef enum logic [1:0] {
        FF_HOLD   = 2'd0,
        FF_TOGGLE = 2'd1,
        FF_SET    = 2'd2,
        FF_CLR    = 2'd3
    } ff_act_t;

    function automatic ff_act_t pick_action(input logic clr, input logic set,
                                            input logic run, input logic hit);
        if (clr)             return FF_CLR;
        else if (set)        return FF_SET;
        else if (run && hit) return FF_TOGGLE;
        else                 return FF_HOLD;
    endfunction

    function automatic logic apply_action(input ff_act_t act, input logic cur);
        case (act)
            FF_CLR:    return 1'b0;
            FF_SET:    return 1'b1;
            FF_TOGGLE: return ~cur;
            default:   return cur;
        endcase
    endfunction
endpackage

// File: rtl/ppg_counter.sv
module ppg_counter
    import ppg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  cmp_pair_t cmp_in,
    output cnt_t      count,
    output cmp_pair_t active
);
    logic at_end;
    logic reload;

    assign at_end = (count == active.period);
    assign reload = !run || at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            active <= '0;
        end else begin
            if (!run || at_end) count <= '0;
            else                count <= count + 1'b1;
            if (reload) active <= cmp_in;
        end
    end

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (rst)
        !run |=> (count == '0));

    p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (run && count == active.period) |=> (count == '0));

    p_bound_r2: assert property (@(posedge clk) disable iff (rst)
        run |-> (count <= active.period));

    p_shadow_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (run && count != active.period) |=> $stable(active));
endmodule

// File: rtl/ppg_match.sv
module ppg_match
    import ppg_pkg::*;
(
    input  cnt_t      count,
    input  cmp_pair_t active,
    output logic      hit
);
    logic [1:0] eq;

    always_comb begin
        eq[0] = (count == active.width);
        eq[1] = (count == active.period);
        hit   = |eq;
    end
endmodule

// File: rtl/ppg_outff.sv
module ppg_outff
    import ppg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic hit,
    input  logic lvl_set,
    input  logic lvl_clr,
    output logic level
);
    ff_act_t act;

    always_comb act = pick_action(lvl_clr, lvl_set, run, hit);

    always_ff @(posedge clk) begin
        if (rst) level <= 1'b0;
        else     level <= apply_action(act, level);
    end

    p_clr_wins_r6: assert property (@(posedge clk) disable iff (rst)
        lvl_clr |=> !level);

    p_set_r6: assert property (@(posedge clk) disable iff (rst)
        (lvl_set && !lvl_clr) |=> level);

    p_toggle_r3: assert property (@(posedge clk) disable iff (rst)
        (run && hit && !lvl_set && !lvl_clr) |=> (level != $past(level)));

    p_idle_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (!run && !lvl_set && !lvl_clr) |=> $stable(level));
endmodule

// File: rtl/ppg_timer.sv
module ppg_timer
    import ppg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PPG_W-1:0] period_cmp,
    input  logic [PPG_W-1:0] width_cmp,
    input  logic             out_en,
    input  logic             lvl_set,
    input  logic             lvl_clr,
    output logic             pulse_o
);
    cmp_pair_t cmp_in;
    cmp_pair_t active;
    cnt_t      count;
    logic      hit;
    logic      level;

    assign cmp_in.period = period_cmp;
    assign cmp_in.width  = width_cmp;

    ppg_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .cmp_in (cmp_in),
        .count  (count),
        .active (active)
    );

    ppg_match u_match (
        .count  (count),
        .active (active),
        .hit    (hit)
    );

    ppg_outff u_ff (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .hit     (hit),
        .lvl_set (lvl_set),
        .lvl_clr (lvl_clr),
        .level   (level)
    );

    assign pulse_o = out_en & level;

    p_reset_low_r9: assert property (@(posedge clk) rst |=> !level);
endmodule

// File: tb/ppg_timer_tb.sv
`timescale 1ns/1ps
module ppg_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        run;
    logic [15:0] period_cmp;
    logic [15:0] width_cmp;
    logic        out_en;
    logic        lvl_set;
    logic        lvl_clr;
    logic        pulse_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ppg_timer dut_i (
        .clk(clk), .rst(rst), .run(run), .period_cmp(period_cmp),
        .width_cmp(width_cmp), .out_en(out_en), .lvl_set(lvl_set),
        .lvl_clr(lvl_clr), .pulse_o(pulse_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Stops the timer and programs the starting level and the compare pair.
    task automatic prepare(input int p, input int w, input logic lvl);
        @(negedge clk);
        run = 1'b0; period_cmp = 16'(p); width_cmp = 16'(w);
        lvl_set = lvl; lvl_clr = !lvl;
        @(negedge clk);
        lvl_set = 1'b0; lvl_clr = 1'b0;
        @(negedge clk);
        check("R7", pulse_o, lvl & out_en);
    endtask

    // Runs n edges and compares each one with the model. At edge chg_at the
    // inputs switch to (p2,w2). The enable is dropped during edges [off_a, off_b).
    task automatic run_wave(input string tag, input int p, input int w, input logic lvl,
                            input int n, input int chg_at, input int p2, input int w2,
                            input int off_a, input int off_b);
        int c  = 0;
        int pa = p;
        int wa = w;
        logic m = lvl;
        int inv_cnt = 0;
        int full = 0;
        run = 1'b1;
        for (int j = 0; j < n; j++) begin
            if (j == chg_at) begin
                period_cmp = 16'(p2); width_cmp = 16'(w2);
            end
            out_en = !(j >= off_a && j < off_b);
            @(posedge clk);
            if (c == wa || c == pa) m = !m;
            if (c == pa) begin
                c = 0; pa = int'(period_cmp); wa = int'(width_cmp);
                if (chg_at >= n) full++;
            end else c++;
            @(negedge clk);
            check(tag, pulse_o, m & out_en);
            if (full < 3 && chg_at >= n && pulse_o != lvl) inv_cnt++;
        end
        if (chg_at >= n && off_a >= n && full >= 3)
            check_int("R4", inv_cnt, 3 * (p - w));
        out_en = 1'b1;
        run = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R9", pulse_o, 1'b0);
    endtask

    task automatic t_levels;
        @(negedge clk); lvl_set = 1'b1; lvl_clr = 1'b0;
        @(negedge clk); check("R6", pulse_o, 1'b1);
        lvl_set = 1'b1; lvl_clr = 1'b1;
        @(negedge clk); check("R6", pulse_o, 1'b0);
        lvl_set = 1'b1; lvl_clr = 1'b0;
        @(negedge clk); lvl_set = 1'b0;
        repeat (5) @(negedge clk);
        check("R7", pulse_o, 1'b1);
        out_en = 1'b0; #1;
        check("R5", pulse_o, 1'b0);
        out_en = 1'b1; #1;
        check("R5", pulse_o, 1'b1);
    endtask

    task automatic t_first_toggle;
        int seen = -1;
        prepare(20, 7, 1'b0);
        run = 1'b1;
        for (int j = 0; j < 15; j++) begin
            @(negedge clk);
            if (seen < 0 && pulse_o) seen = j;
        end
        run = 1'b0;
        check_int("R1", seen, 7);
        @(negedge clk);
        check("R1", pulse_o, 1'b1);
    endtask

    initial begin
        rst = 1'b1; run = 1'b0; period_cmp = '0; width_cmp = '0;
        out_en = 1'b1; lvl_set = 1'b0; lvl_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_levels();
        t_first_toggle();
        prepare(9, 3, 1'b0);   run_wave("R3", 9, 3, 1'b0, 60, 1000, 0, 0, 1000, 1000);
        prepare(4, 1, 1'b0);   run_wave("R2", 4, 1, 1'b0, 40, 1000, 0, 0, 1000, 1000);
        prepare(15, 14, 1'b1); run_wave("R3", 15, 14, 1'b1, 70, 1000, 0, 0, 1000, 1000);
        prepare(300, 100, 1'b0); run_wave("R4", 300, 100, 1'b0, 1000, 5000, 0, 0, 5000, 5000);
        prepare(9, 3, 1'b0);   run_wave("R8", 9, 3, 1'b0, 60, 4, 5, 2, 1000, 1000);
        prepare(12, 5, 1'b1);  run_wave("R8", 12, 5, 1'b1, 60, 15, 6, 4, 1000, 1000);
        prepare(8, 2, 1'b0);   run_wave("R5", 8, 2, 1'b0, 50, 1000, 0, 0, 5, 22);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule